// File: doc/BRIEF.md
# MSI-X Capability Register Block

This block holds the MSI-X capability structure that a PCI function exposes in its configuration space. The structure is twelve bytes long. It carries a fixed capability identifier, a pointer to the next capability, a message control word, and two dwords that tell software where the vector table and the pending-bit array live inside a memory BAR. Configuration accesses reach the block at a byte offset relative to the start of the structure. A single access may be one, two or four bytes wide.

Only two bits can be written: the global MSI-X enable and the function-wide mask. A write is merged lane by lane, so the read-only vector count sharing the control word with these bits is never disturbed. The enable and mask drive the rest of the interrupt logic directly. If a write takes either bit from 1 to 0, the block raises a single-cycle rescan request. This tells the vector table controller, which is outside this block, to deliver every vector that became pending while delivery was blocked.

Top module: `msix_cap_regs`

## Requirements
- R1: Offset 0 reads 0x11 and offset 1 reads the NEXT_PTR parameter. Writes to either offset leave the read value unchanged.
- R2: Offsets 2 and 3 form the 16-bit message control word. Bits 10:0 read NUM_VECTORS-1 and bits 13:11 read 0. None of bits 13:0 can be changed by a write.
- R3: Message control bit 15 is the enable bit and bit 14 is the function mask bit. Both reset to 0, both take the written value, and they appear on `msix_enable` and `func_mask` from the clock edge of the write onward.
- R4: A write of n bytes at offset k places data byte i (bits 8i+7:8i) at offset k+i. Only the byte that lands on offset 3 changes state.
- R5: `rescan_req` is high in the cycle after a write that clears enable or mask from 1 to 0. It stays low after writes that only set bits or that leave them unchanged.
- R6: Each qualifying write raises `rescan_req` for exactly one clock cycle.
- R7: The dword at offset 4 reads BAR_INDEX and the dword at offset 8 reads 0x800 | BAR_INDEX. Both are read-only, and BAR_INDEX must lie between 0 and 5.
- R8: `acc_size` 0, 1 and 2 select 1, 2 and 4 bytes. `rd_data` returns them little-endian from the addressed byte, with unused upper lanes at 0. `acc_size` 3 reads 0 and its writes are ignored.
- R9: Bytes at offsets 12 and above read as 0 and ignore writes, including bytes of an access that only partly lies beyond the structure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_off | input | OFF_W | Byte offset relative to the capability base |
| acc_size | input | 2 | Access width code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = none |
| wr_en | input | 1 | Write strobe, taken at the rising clock edge |
| wr_data | input | 32 | Write data, byte i goes to offset acc_off+i |
| rd_data | output | 32 | Combinational read data, little-endian |
| msix_enable | output | 1 | Global MSI-X enable |
| func_mask | output | 1 | Function-wide vector mask |
| rescan_req | output | 1 | One-cycle request to re-check all pending vectors |

## Verification
A corrupted enable or mask register shows up on its output pin in the same cycle, and also on byte 3 of a read at offset 2 or 3. A fault that writes the wrong lane shows up at the first write whose data differs between lanes. A wrong read image, such as a changed vector count, BAR field or zero fill, shows up combinationally on the next read of the affected offset. A rescan error shows up one cycle after the write that should or should not have caused it, because the bench compares the pulse against its own model of the enable and mask bits every cycle.

// File: rtl/msix_cap_pkg.sv
package msix_cap_pkg;
  localparam logic [7:0]  CAP_ID_MSIX   = 8'h11;
  localparam int          CAP_BYTES     = 12;
  localparam int          CTL_HI_OFF    = 3;
  localparam int          LANES         = 4;
  localparam logic [31:0] PBA_BASE      = 32'h0000_0800;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_NONE  = 2'd3
  } acc_size_e;

  function automatic int unsigned size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE:  return 1;
      SZ_WORD:  return 2;
      SZ_DWORD: return 4;
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/msix_lane_decode.sv
module msix_lane_decode
  import msix_cap_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic [OFF_W-1:0]            acc_off,
  input  logic [1:0]                  acc_size,
  output logic [LANES-1:0][OFF_W:0]   lane_off,
  output logic [LANES-1:0]            lane_vld
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic used;
    assign lane_off[i] = {1'b0, acc_off} + (OFF_W+1)'(i);
    assign used        = (i < size_bytes(acc_size));
    assign lane_vld[i] = used && (lane_off[i] < (OFF_W+1)'(CAP_BYTES));
  end
endmodule

// File: rtl/msix_cap_ctrl.sv
module msix_cap_ctrl
  import msix_cap_pkg::*;
#(
  parameter int OFF_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [31:0]                 wr_data,
  input  logic [LANES-1:0][OFF_W:0]   lane_off,
  input  logic [LANES-1:0]            lane_vld,
  output logic                        en_q,
  output logic                        mask_q,
  output logic                        rescan_q
);
  logic en_d, mask_d, rescan_d, upd;

  always_comb begin
    en_d   = en_q;
    mask_d = mask_q;
    for (int i = 0; i < LANES; i++) begin
      if (wr_en && lane_vld[i] && (lane_off[i] == (OFF_W+1)'(CTL_HI_OFF))) begin
        en_d   = wr_data[8*i+7];
        mask_d = wr_data[8*i+6];
      end
    end
    rescan_d = (en_q && !en_d) || (mask_q && !mask_d);
    upd      = wr_en || rescan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      mask_q   <= 1'b0;
      rescan_q <= 1'b0;
    end else if (upd) begin
      en_q     <= en_d;
      mask_q   <= mask_d;
      rescan_q <= rescan_d;
    end
  end

  // A rescan follows a falling control bit, and only that.
  p_fall_gives_rescan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(en_q) || $fell(mask_q)) |-> rescan_q);
  p_rescan_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rescan_q |-> ($fell(en_q) || $fell(mask_q)));
  p_state_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(en_q) && $stable(mask_q)));
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rescan_q && !wr_en) |=> !rescan_q);
endmodule

// File: rtl/msix_cap_rdmux.sv
module msix_cap_rdmux
  import msix_cap_pkg::*;
#(
  parameter int         OFF_W       = 8,
  parameter int         NUM_VECTORS = 8,
  parameter int         BAR_INDEX   = 0,
  parameter logic [7:0] NEXT_PTR    = 8'h00
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0][OFF_W:0]   lane_off,
  input  logic [LANES-1:0]            lane_vld,
  input  logic                        en_q,
  input  logic                        mask_q,
  output logic [31:0]                 rd_data
);
  localparam logic [10:0] TBL_SIZE = 11'(NUM_VECTORS - 1);
  localparam logic [31:0] TBL_DW   = 32'(BAR_INDEX);
  localparam logic [31:0] PBA_DW   = PBA_BASE | 32'(BAR_INDEX);

  logic [15:0][7:0] image;

  always_comb begin
    image     = '0;
    image[0]  = CAP_ID_MSIX;
    image[1]  = NEXT_PTR;
    image[2]  = TBL_SIZE[7:0];
    image[3]  = {en_q, mask_q, 3'b000, TBL_SIZE[10:8]};
    for (int b = 0; b < 4; b++) begin
      image[4+b] = TBL_DW[8*b +: 8];
      image[8+b] = PBA_DW[8*b +: 8];
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_rd
    assign rd_data[8*i +: 8] = lane_vld[i] ? image[lane_off[i][3:0]] : 8'h00;
  end

  p_oob_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_vld == '0) |-> (rd_data == 32'h0));
  p_enable_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_vld[0] && lane_off[0] == (OFF_W+1)'(CTL_HI_OFF)) |->
      (rd_data[7] == en_q && rd_data[6] == mask_q));
endmodule

// File: rtl/msix_cap_regs.sv
module msix_cap_regs
  import msix_cap_pkg::*;
#(
  parameter int         OFF_W       = 8,
  parameter int         NUM_VECTORS = 8,
  parameter int         BAR_INDEX   = 0,
  parameter logic [7:0] NEXT_PTR    = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFF_W-1:0] acc_off,
  input  logic [1:0]       acc_size,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  output logic             msix_enable,
  output logic             func_mask,
  output logic             rescan_req
);
  if (BAR_INDEX < 0 || BAR_INDEX > 5 || NUM_VECTORS < 1 || NUM_VECTORS > 2048)
  begin : g_bad_param
    $error("msix_cap_regs: parameter out of range");
  end

  logic [LANES-1:0][OFF_W:0] lane_off;
  logic [LANES-1:0]          lane_vld;

  msix_lane_decode #(.OFF_W(OFF_W)) u_dec (
    .acc_off  (acc_off),
    .acc_size (acc_size),
    .lane_off (lane_off),
    .lane_vld (lane_vld)
  );

  msix_cap_ctrl #(.OFF_W(OFF_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .lane_off (lane_off),
    .lane_vld (lane_vld),
    .en_q     (msix_enable),
    .mask_q   (func_mask),
    .rescan_q (rescan_req)
  );

  msix_cap_rdmux #(
    .OFF_W       (OFF_W),
    .NUM_VECTORS (NUM_VECTORS),
    .BAR_INDEX   (BAR_INDEX),
    .NEXT_PTR    (NEXT_PTR)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_off (lane_off),
    .lane_vld (lane_vld),
    .en_q     (msix_enable),
    .mask_q   (func_mask),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/test_msix_cap_regs.sv
module test_msix_cap_regs;
  localparam int         NV  = 8;
  localparam int         BAR = 3;
  localparam logic [7:0] NXT = 8'h5C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  acc_off;
  logic [1:0]  acc_size;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        msix_enable, func_mask, rescan_req;

  int checks = 0;
  int errors = 0;
  bit m_en, m_mask, m_resc;

  always #10 clk = ~clk;

  msix_cap_regs #(.NUM_VECTORS(NV), .BAR_INDEX(BAR), .NEXT_PTR(NXT)) i_msix_cap_regs (
    .clk(clk), .rst_n(rst_n), .acc_off(acc_off), .acc_size(acc_size),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .msix_enable(msix_enable), .func_mask(func_mask), .rescan_req(rescan_req)
  );

  function automatic logic [7:0] img(input int idx, input bit en, input bit mk);
    logic [15:0] ctl;
    ctl = {en, mk, 3'b000, 11'(NV - 1)};
    case (idx)
      0: return 8'h11;
      1: return NXT;
      2: return ctl[7:0];
      3: return ctl[15:8];
      4: return 8'(BAR);
      8: return 8'(BAR);
      9: return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 0;
  endfunction

  function automatic logic [31:0] exp_rd(input int off, input logic [1:0] s,
                                         input bit en, input bit mk);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++)
      if (i < nbytes(s) && off + i < 12) r[8*i +: 8] = img(off + i, en, mk);
    return r;
  endfunction

  function automatic string rd_tag(input int off, input logic [1:0] s);
    if (s == 2'd3) return "R8";
    if (off >= 12) return "R9";
    if (off < 2)   return "R1";
    if (off < 4)   return "R2";
    return "R7";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_outs();
    chk("R3 enable", {31'b0, msix_enable}, {31'b0, m_en});
    chk("R3 mask",   {31'b0, func_mask},   {31'b0, m_mask});
    chk("R5 rescan", {31'b0, rescan_req},  {31'b0, m_resc});
  endtask

  // One access: check outputs, drive, check read, model the edge.
  task automatic access(input int off, input logic [1:0] s, input bit we, input logic [31:0] d);
    bit ne, nm;
    @(negedge clk);
    chk_outs();
    acc_off = 8'(off); acc_size = s; wr_en = we; wr_data = d;
    #1;
    chk(rd_tag(off, s), rd_data, exp_rd(off, s, m_en, m_mask));
    ne = m_en; nm = m_mask;
    if (we)
      for (int i = 0; i < nbytes(s); i++)
        if (off + i == 3) begin ne = d[8*i+7]; nm = d[8*i+6]; end
    @(posedge clk);
    m_resc = (m_en && !ne) || (m_mask && !nm);
    m_en = ne; m_mask = nm;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; acc_off = '0; acc_size = 2'd0; wr_en = 1'b0; wr_data = '0;
    m_en = 0; m_mask = 0; m_resc = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R3 reset enable", {31'b0, msix_enable}, 32'h0);
    chk("R3 reset mask",   {31'b0, func_mask},   32'h0);
    chk("R5 reset rescan", {31'b0, rescan_req},  32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R4: word write at offset 2, high lane sets both bits
    access(2, 2'd1, 1'b1, 32'h0000_C0FF);
    // R1/R2: read of id and control after set
    access(0, 2'd2, 1'b0, 32'h0);
    // R5/R6: dword write at 0 clears both; pulse then drops
    access(0, 2'd2, 1'b1, 32'h0000_0000);
    access(2, 2'd1, 1'b0, 32'h0);
    access(2, 2'd1, 1'b0, 32'h0);
    // R5: set-only write gives no pulse; byte write at 3
    access(3, 2'd0, 1'b1, 32'h0000_0080);
    access(3, 2'd0, 1'b1, 32'h0000_00C0);
    // R5: clear only mask
    access(3, 2'd0, 1'b1, 32'h0000_0080);
    // R7: write to table and PBA dwords ignored
    access(4, 2'd2, 1'b1, 32'hFFFF_FFFF);
    access(8, 2'd2, 1'b1, 32'hFFFF_FFFF);
    access(4, 2'd2, 1'b0, 32'h0);
    access(8, 2'd2, 1'b0, 32'h0);
    // R9: straddling read and write beyond the end
    access(10, 2'd2, 1'b1, 32'hFFFF_FFFF);
    access(12, 2'd2, 1'b0, 32'h0);
    // R8: size 3 write ignored, reads zero
    access(2, 2'd3, 1'b1, 32'h0000_0000);
    // R4: lane 1 of dword write at 2 hits offset 3
    access(2, 2'd2, 1'b1, 32'h0000_4000);
    access(1, 2'd2, 1'b1, 32'h0000_0000);

    for (int n = 0; n < 400; n++) begin
      int off = $urandom_range(0, 15);
      logic [1:0] s = 2'($urandom_range(0, 3));
      access(off, s, 1'($urandom_range(0, 1)), $urandom());
    end
    @(negedge clk);
    chk_outs();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule